// File: doc/BRIEF.md
# Interval Timer Channel with PWM Output

This block is one timer channel with a small register port. Software writes a clock setup word, a control word, a period limit and a duty threshold. A prescaler turns the input clock into a tick stream. A 16-bit counter advances once per tick. The counter can count up or down. It can also wrap at the programmed limit, which is interval mode. The waveform output compares the count with the duty threshold, which gives a PWM signal. A polarity bit inverts that signal. A separate off bit forces the output low.

Limit and threshold writes are staged. The counter uses new values only from the next wrap, or straight away after a restart. This means a running waveform can be retuned without producing a short or torn period. Both counting and the waveform come out of reset disabled.

Top module: `ttc_pwm_channel`

## Requirements
- R1: After reset the control word at offset 0x0C reads 0x21 (bit 0 halt = 1, bit 5 waveform off = 1). The clock setup word at offset 0x00, the limit at 0x24 and the threshold at 0x30 all read 0. tick_o and wave_o are 0.
- R2: The limit and the threshold keep only their low 16 bits. The clock setup word reads back bit 0 (prescale on) and bits 4:1 (prescale select), and reads 0 in every other bit. The control word reads back bits 0-3 and 5-6, and reads 0 in bit 4 and above.
- R3: Writing 1 to control bit 4 restarts the channel on the next clock edge. The count goes to 0, the prescaler phase goes to 0, and the staged limit and threshold take effect. The bit is a one-cycle pulse and never reads back as 1.
- R4: With prescale off, tick_o is high on every clock while counting runs. With prescale on and select value N, tick_o is high once every 2^(N+1) clocks, on the last clock of each group counted from the restart.
- R5: While control bit 0 (halt) is 1, tick_o stays 0 and the count holds its value.
- R6: With control bit 1 (interval mode) set and bit 2 clear, the count runs 0, 1, ..., L and then wraps to 0, where L is the active limit. One period is L+1 ticks.
- R7: With control bit 3 (match enable) set, the level before polarity is high while count < M, where M is the active threshold, and low otherwise. M = 0 gives a constant low level. With match enable clear, the level is low.
- R8: Control bit 6 (polarity) inverts the level that reaches wave_o.
- R9: While control bit 5 (waveform off) is 1, wave_o is 0 whatever the polarity. Ticks continue as normal.
- R10: With control bit 2 (count down) set in interval mode, the count steps down by one per tick. From 0 it wraps to L.
- R11: A limit or threshold write while the channel is running does not change the waveform until the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| tick_o | output | 1 | High on clocks where the counter advances |
| wave_o | output | 1 | PWM waveform |

## Verification
The hardest case to create from the ports is a threshold write that lands in the middle of a period. The old threshold must hold until the wrap, and the new one must appear on the first tick after it. The bench produces this case by issuing the write on the first clock after a restart. This places the write at a known count within period 0. The bench then predicts the full waveform across the wrap. A halt that lands between two ticks is handled the same way. In that case the frozen count must keep a low level that the running count would have left.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

    localparam logic [5:0] OFS_CLK   = 6'h00;
    localparam logic [5:0] OFS_CTRL  = 6'h0C;
    localparam logic [5:0] OFS_LIMIT = 6'h24;
    localparam logic [5:0] OFS_THR   = 6'h30;

    localparam int SEL_W = 4;
    localparam int PRE_W = (1 << SEL_W) + 1;

    typedef struct packed {
        logic             pre_on;
        logic [SEL_W-1:0] pre_sel;
    } clk_cfg_t;

    typedef struct packed {
        logic pol;
        logic wave_off;
        logic match_on;
        logic down;
        logic intv;
        logic halt;
    } ctl_cfg_t;

    localparam ctl_cfg_t CTL_RESET = '{pol: 1'b0, wave_off: 1'b1, match_on: 1'b0,
                                       down: 1'b0, intv: 1'b0, halt: 1'b1};

    function automatic logic [31:0] pack_clk(clk_cfg_t c);
        return {27'd0, c.pre_sel, c.pre_on};
    endfunction

    function automatic logic [31:0] pack_ctl(ctl_cfg_t c);
        return {25'd0, c.pol, c.wave_off, 1'b0, c.match_on, c.down, c.intv, c.halt};
    endfunction

    function automatic ctl_cfg_t unpack_ctl(logic [31:0] w);
        ctl_cfg_t c;
        c.halt     = w[0];
        c.intv     = w[1];
        c.down     = w[2];
        c.match_on = w[3];
        c.wave_off = w[5];
        c.pol      = w[6];
        return c;
    endfunction

endpackage

// File: rtl/ttc_regs.sv
module ttc_regs
    import ttc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [5:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output clk_cfg_t         clk_cfg,
    output ctl_cfg_t         ctl_cfg,
    output logic             restart,
    output logic [CNT_W-1:0] limit_prog,
    output logic [CNT_W-1:0] thr_prog
);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_cfg    <= '0;
            ctl_cfg    <= CTL_RESET;
            restart    <= 1'b0;
            limit_prog <= '0;
            thr_prog   <= '0;
        end else begin
            restart <= 1'b0;
            if (wr_en) begin
                unique case (addr)
                    OFS_CLK: begin
                        clk_cfg.pre_on  <= wdata[0];
                        clk_cfg.pre_sel <= wdata[SEL_W:1];
                    end
                    OFS_CTRL: begin
                        ctl_cfg <= unpack_ctl(wdata);
                        restart <= wdata[4];
                    end
                    OFS_LIMIT: limit_prog <= wdata[CNT_W-1:0];
                    OFS_THR:   thr_prog   <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            OFS_CLK:   rdata = pack_clk(clk_cfg);
            OFS_CTRL:  rdata = pack_ctl(ctl_cfg);
            OFS_LIMIT: rdata = 32'(limit_prog);
            OFS_THR:   rdata = 32'(thr_prog);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/ttc_prescaler.sv
module ttc_prescaler
    import ttc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     halt,
    input  clk_cfg_t cfg,
    output logic     tick
);

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] last;
    logic             at_end;

    assign last   = (PRE_W'(2) << cfg.pre_sel) - PRE_W'(1);
    assign at_end = (phase >= last);
    assign tick   = !halt && !restart && (!cfg.pre_on || at_end);

    always_ff @(posedge clk) begin
        if (rst || restart || !cfg.pre_on) begin
            phase <= '0;
        end else if (!halt) begin
            phase <= at_end ? '0 : phase + PRE_W'(1);
        end
    end

endmodule

// File: rtl/ttc_counter.sv
module ttc_counter
    import ttc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic             intv,
    input  logic             down,
    input  logic [CNT_W-1:0] limit_prog,
    input  logic [CNT_W-1:0] thr_prog,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] limit_act,
    output logic [CNT_W-1:0] thr_act,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] TOP = '1;

    logic             at_edge;
    logic [CNT_W-1:0] wrap_val;

    always_comb begin
        if (down) begin
            at_edge  = (count == '0);
            wrap_val = intv ? limit_prog : TOP;
        end else begin
            at_edge  = intv ? (count == limit_act) : (count == TOP);
            wrap_val = '0;
        end
    end

    assign wrap = tick && at_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            limit_act <= '0;
            thr_act   <= '0;
        end else if (restart) begin
            count     <= '0;
            limit_act <= limit_prog;
            thr_act   <= thr_prog;
        end else if (wrap) begin
            count     <= wrap_val;
            limit_act <= limit_prog;
            thr_act   <= thr_prog;
        end else if (tick) begin
            count <= down ? count - CNT_W'(1) : count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ttc_wave.sv
module ttc_wave
    import ttc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr_act,
    input  ctl_cfg_t         ctl,
    output logic             wave
);

    logic level;

    assign level = ctl.match_on && (count < thr_act);
    assign wave  = !ctl.wave_off && (level ^ ctl.pol);

endmodule

// File: rtl/ttc_pwm_channel.sv
module ttc_pwm_channel
    import ttc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [5:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        tick_o,
    output logic        wave_o
);

    clk_cfg_t         clk_cfg;
    ctl_cfg_t         ctl_cfg;
    logic             restart;
    logic [CNT_W-1:0] limit_prog, thr_prog;
    logic [CNT_W-1:0] count, limit_act, thr_act;
    logic             wrap;

    ttc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .clk_cfg(clk_cfg), .ctl_cfg(ctl_cfg), .restart(restart),
        .limit_prog(limit_prog), .thr_prog(thr_prog)
    );

    ttc_prescaler u_pre (
        .clk(clk), .rst(rst), .restart(restart), .halt(ctl_cfg.halt),
        .cfg(clk_cfg), .tick(tick_o)
    );

    ttc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .restart(restart), .tick(tick_o),
        .intv(ctl_cfg.intv), .down(ctl_cfg.down),
        .limit_prog(limit_prog), .thr_prog(thr_prog),
        .count(count), .limit_act(limit_act), .thr_act(thr_act), .wrap(wrap)
    );

    ttc_wave #(.CNT_W(CNT_W)) u_wave (
        .count(count), .thr_act(thr_act), .ctl(ctl_cfg), .wave(wave_o)
    );

endmodule

// File: rtl/ttc_pwm_checker.sv
module ttc_pwm_checker
    import ttc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input ctl_cfg_t         ctl_cfg,
    input logic             restart,
    input logic             tick_o,
    input logic             wave_o,
    input logic             wrap,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] limit_act,
    input logic [CNT_W-1:0] thr_act
);

    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart); // R3

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> count == '0); // R3

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ctl_cfg.halt && !restart |=> $stable(count)); // R5

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        tick_o && ctl_cfg.intv && !ctl_cfg.down && count == limit_act |=> count == '0); // R6

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        ctl_cfg.wave_off |-> !wave_o); // R9

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        tick_o && ctl_cfg.down && count != '0 |=> count == $past(count) - CNT_W'(1)); // R10

    AST_THR_STAGED: assert property (@(posedge clk) disable iff (rst)
        !restart && !wrap |=> $stable(thr_act)); // R11

endmodule

bind ttc_pwm_channel ttc_pwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .ctl_cfg(ctl_cfg), .restart(restart), .tick_o(tick_o),
    .wave_o(wave_o), .wrap(wrap), .count(count), .limit_act(limit_act),
    .thr_act(thr_act)
);

// File: tb/tb_ttc_pwm_channel.sv
module tb_ttc_pwm_channel;

    typedef struct {
        logic  tick;
        logic  wave;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_o, wave_o;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    ttc_pwm_channel dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_o(tick_o), .wave_o(wave_o)
    );

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (tick_o !== e.tick || wave_o !== e.wave) begin
                errors++;
                $display("FAIL %s: tick/wave actual %b%b expected %b%b at %0t",
                         e.req, tick_o, wave_o, e.tick, e.wave, $time);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg 0x%0h actual 0x%0h expected 0x%0h", req, a, rdata, exp);
        end
    endtask

    // pre: 0 = prescale off, otherwise select value + 1; mid: 0 none, 1 threshold rewrite, 2 halt
    task automatic run(input int pre, input int lim, input int thr, input int thr2,
                       input bit down, input bit mon, input bit pol, input bit off,
                       input int mid, input int len, input string req);
        int d;
        int cnt;
        int act;
        logic [31:0] ctl;
        d = (pre == 0) ? 1 : (2 << (pre - 1));
        wr(6'h0C, 32'h21);
        wr(6'h00, (pre == 0) ? 32'h0 : ((32'(pre - 1) << 1) | 32'h1));
        wr(6'h24, 32'(lim));
        wr(6'h30, 32'(thr));
        ctl = (32'(pol) << 6) | (32'(off) << 5) | 32'h10 | (32'(mon) << 3) | (32'(down) << 2) | 32'h2;
        wr(6'h0C, ctl);
        @(posedge clk);
        cnt = 0;
        act = thr;
        for (int k = 0; k < len; k++) begin
            exp_t e;
            logic tk;
            tk = (mid != 2 || k < 1) && ((k % d) == d - 1);
            e.tick = tk;
            e.wave = !off && ((mon && cnt < act) ^ pol);
            e.req  = req;
            exp_q.push_back(e);
            if (tk) begin
                if (down ? (cnt == 0) : (cnt == lim)) begin
                    cnt = down ? lim : 0;
                    act = (mid == 1 && k >= 1) ? thr2 : thr;
                end else begin
                    cnt = down ? cnt - 1 : cnt + 1;
                end
            end
        end
        if (mid == 1) wr(6'h30, 32'(thr2));
        if (mid == 2) wr(6'h0C, (ctl & ~32'h10) | 32'h1);
        wait (exp_q.size() == 0);
        @(posedge clk);
    endtask

    initial begin
        #(1_500_000);
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset values
        rd_check(6'h0C, 32'h21, "R1");
        rd_check(6'h00, 32'h0, "R1");
        rd_check(6'h24, 32'h0, "R1");
        rd_check(6'h30, 32'h0, "R1");
        checks++;
        if (tick_o !== 1'b0 || wave_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: tick/wave actual %b%b expected 00", tick_o, wave_o);
        end
        // R2 masking, R3 restart bit reads 0
        wr(6'h24, 32'h0001_2345);
        rd_check(6'h24, 32'h2345, "R2");
        wr(6'h30, 32'hFFFF_0007);
        rd_check(6'h30, 32'h0007, "R2");
        wr(6'h00, 32'hFFFF_FFFF);
        rd_check(6'h00, 32'h1F, "R2");
        wr(6'h0C, 32'hFFFF_FFFF);
        rd_check(6'h0C, 32'h6F, "R3");

        run(0, 4, 2, 0, 0, 1, 0, 0, 0, 15, "R6");
        run(0, 5, 3, 0, 0, 1, 0, 0, 0, 14, "R7");
        run(1, 3, 1, 0, 0, 1, 0, 0, 0, 20, "R4");
        run(2, 2, 1, 0, 0, 1, 0, 0, 0, 26, "R4");
        run(0, 3, 1, 0, 0, 1, 1, 0, 0, 10, "R8");
        run(0, 3, 0, 0, 0, 1, 0, 0, 0, 8, "R7");
        run(0, 3, 2, 0, 0, 0, 0, 0, 0, 8, "R7");
        run(0, 3, 0, 0, 0, 1, 1, 0, 0, 8, "R8");
        run(0, 3, 1, 0, 0, 1, 1, 1, 0, 10, "R9");
        run(0, 3, 2, 0, 1, 1, 0, 0, 0, 12, "R10");
        run(0, 4, 1, 3, 0, 1, 0, 0, 1, 15, "R11");
        run(0, 3, 1, 0, 0, 1, 0, 0, 2, 10, "R5");
        run(1, 2, 1, 0, 0, 1, 0, 0, 0, 12, "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule